// File: doc/BRIEF.md
# Timer Capture Input Conditioner

This block turns raw timer channel pins into capture events for a four-channel timer. Each channel cleans its pin with a programmable sampling filter and detects the edges it should react to. It then picks where its capture event comes from and thins the event stream with a small divider. When an event survives that chain, the block stores the free-running timer count that the timer core supplies.

Channel 1 can watch either its own pin or the parity (XOR) of pins 1 to 3. This suits sensors that share one timing input. Channels are paired (1 with 2, 3 with 4). A channel can run its partner's filtered signal through its own edge detector, so two channels can capture opposite edges of one pin. An external trigger can also serve as the capture source. Software-side access is reduced to level configuration inputs and strobes for configuration writes, flag clears and capture reads.

Top module: `tmr_capture_cond`

## Requirements
- R1: After reset every capture value is 0 and every capture flag and overcapture flag is 0.
- R2: With filter code 0 the filtered signal follows the pin one clock later, so a pin change driven before clock edge k produces a capture at edge k+1.
- R3: With a nonzero filter code c, let i = c-1. Then N = 2 << (i mod 3), and the pin is sampled once every 2^(i/3) clocks. The filtered signal takes the pin's new level only after N consecutive samples at that level, so shorter pulses produce no capture.
- R4: Each channel has a polarity input pol and a both-edges input both. If both=1, rising and falling edges are events. Otherwise pol=0 selects rising edges only and pol=1 selects falling edges only.
- R5: When the channel-1 parity select is 1, channel 1's raw signal is pin1 XOR pin2 XOR pin3. When it is 0, channel 1 uses pin 1 alone and is not affected by pin 3.
- R6: The source code is 2 bits per channel. Code 0 selects the channel's own edge events. Code 1 selects the paired channel's filtered signal (1 with 2, 3 with 4) through this channel's edge detector. Code 2 selects the external trigger input. Code 3 selects no source.
- R7: The divider code d (2 bits per channel) passes every 2^d-th selected event, starting from the 2^d-th event after a clear.
- R8: A configuration write strobe for a channel clears that channel's divider count; an event in the same cycle is dropped.
- R9: A passed event stores the count input into the channel's capture value and sets its capture flag on the next clock edge.
- R10: A passed event while the capture flag is already 1 sets the overcapture flag. The overcapture flag is cleared only by the flag clear strobe.
- R11: The capture flag is cleared by the flag clear strobe or by the capture read strobe. A passed event in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NCH | Raw channel pins, bit 0 is channel 1 |
| ch1_xor_i | input | 1 | Channel 1 raw source: 1 selects the parity of pins 1 to 3 |
| flt_cfg_i | input | NCH*FLT_W | Filter code per channel |
| pol_i | input | NCH | Polarity per channel, 1 selects falling |
| both_i | input | NCH | Both-edges select per channel |
| src_sel_i | input | NCH*2 | Capture source code per channel |
| div_i | input | NCH*2 | Event divider code per channel |
| cfg_wr_i | input | NCH | Configuration write strobe per channel |
| trig_i | input | 1 | External trigger event |
| count_i | input | CNT_W | Current timer count |
| flag_clr_i | input | NCH | Flag clear strobe per channel |
| cap_rd_i | input | NCH | Capture register read strobe per channel |
| cap_val_o | output | NCH*CNT_W | Capture values, channel 1 in the low bits |
| cap_flag_o | output | NCH | Capture flags |
| ovr_flag_o | output | NCH | Overcapture flags |

## Verification
The hardest case to reach is the filter's rejection boundary. The bench must hold a pin for exactly N-1 and then exactly N sample points, and the sample phase is not visible at the ports. The stimulus reaches it in two ways. With every-clock sampling it uses pulses one cycle apart in length. With halved-rate sampling it uses pulse lengths chosen so the result does not depend on phase: one cycle can be sampled at most once, and five cycles are always sampled at least twice. A second hard case is a capture arriving in the very cycle of a flag clear. The bench reaches it by lining up a trigger pulse with the clear strobe on the same clock.

// File: rtl/cap_cond_pkg.sv
package cap_cond_pkg;
   typedef enum logic [1:0] {
      SRC_OWN  = 2'd0,
      SRC_PAIR = 2'd1,
      SRC_TRIG = 2'd2,
      SRC_NONE = 2'd3
   } cap_src_e;
endpackage

// File: rtl/cap_filter.sv
module cap_filter #(
   parameter int FLT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_i,
   input  logic [FLT_W-1:0] code_i,
   output logic             filt_o
);
   localparam int MAX_SH = ((1 << FLT_W) - 2) / 3;
   localparam int DW     = MAX_SH + 1;

   logic [FLT_W-1:0] idx, sh, nsel;
   logic [DW-1:0]    div_q, div_lim;
   logic [2:0]       run_q, run_lim;
   logic             smp, filt_q;

   always_comb begin
      idx     = code_i - FLT_W'(1);
      sh      = idx / FLT_W'(3);
      nsel    = idx % FLT_W'(3);
      div_lim = (DW'(1) << sh) - DW'(1);
      case (nsel)
         FLT_W'(0): run_lim = 3'd1;
         FLT_W'(1): run_lim = 3'd3;
         default:   run_lim = 3'd7;
      endcase
      smp = (div_q == div_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         run_q  <= '0;
         div_q  <= '0;
      end else if (code_i == '0) begin
         filt_q <= raw_i;
         run_q  <= '0;
         div_q  <= '0;
      end else begin
         div_q <= smp ? '0 : div_q + DW'(1);
         if (smp) begin
            if (raw_i != filt_q) begin
               if (run_q == run_lim) begin
                  filt_q <= raw_i;
                  run_q  <= '0;
               end else begin
                  run_q <= run_q + 3'd1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   end

   assign filt_o = filt_q;

   AST_FLT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == '0) |=> (filt_q == $past(raw_i)));            // R2
   AST_FLT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q) |-> (filt_q == $past(raw_i)));           // R3
endmodule

// File: rtl/cap_edge_sel.sv
module cap_edge_sel
   import cap_cond_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       own_i,
   input  logic       pair_i,
   input  logic       pol_i,
   input  logic       both_i,
   input  cap_src_e   src_i,
   input  logic       trig_i,
   input  logic [1:0] div_i,
   input  logic       cfg_wr_i,
   output logic       pass_o
);
   logic       own_d, pair_d, own_ev, pair_ev, ev, pass;
   logic [2:0] presc_q, presc_lim;

   function automatic logic edge_hit(input logic cur, input logic prev,
                                     input logic pol, input logic both);
      logic rise, fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      return both ? (rise | fall) : (pol ? fall : rise);
   endfunction

   always_comb begin
      own_ev  = edge_hit(own_i, own_d, pol_i, both_i);
      pair_ev = edge_hit(pair_i, pair_d, pol_i, both_i);
      case (src_i)
         SRC_OWN:  ev = own_ev;
         SRC_PAIR: ev = pair_ev;
         SRC_TRIG: ev = trig_i;
         default:  ev = 1'b0;
      endcase
      presc_lim = (3'd1 << div_i) - 3'd1;
      pass      = ev && !cfg_wr_i && (presc_q >= presc_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_d   <= 1'b0;
         pair_d  <= 1'b0;
         presc_q <= '0;
      end else begin
         own_d  <= own_i;
         pair_d <= pair_i;
         if (cfg_wr_i)  presc_q <= '0;
         else if (ev)   presc_q <= pass ? 3'd0 : presc_q + 3'd1;
      end
   end

   assign pass_o = pass;

   AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_i |=> (presc_q == 3'd0));                           // R8
   AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (div_i == $past(div_i)) |-> (presc_q <= presc_lim));       // R7
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             clr_i,
   input  logic             rd_i,
   output logic [CNT_W-1:0] val_o,
   output logic             flag_o,
   output logic             ovr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_o  <= '0;
         flag_o <= 1'b0;
         ovr_o  <= 1'b0;
      end else begin
         if (pass_i) begin
            val_o  <= count_i;
            flag_o <= 1'b1;
            if (flag_o) ovr_o <= 1'b1;
            else if (clr_i) ovr_o <= 1'b0;
         end else begin
            if (clr_i || rd_i) flag_o <= 1'b0;
            if (clr_i)         ovr_o  <= 1'b0;
         end
      end
   end

   AST_CAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pass_i |=> (flag_o && val_o == $past(count_i)));           // R9
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_i && flag_o) |=> ovr_o);                             // R10
   AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i || rd_i) && !pass_i) |=> !flag_o);                 // R11
endmodule

// File: rtl/tmr_capture_cond.sv
module tmr_capture_cond
   import cap_cond_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int CNT_W = 16,
   parameter int FLT_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       pin_i,
   input  logic                 ch1_xor_i,
   input  logic [NCH*FLT_W-1:0] flt_cfg_i,
   input  logic [NCH-1:0]       pol_i,
   input  logic [NCH-1:0]       both_i,
   input  logic [NCH*2-1:0]     src_sel_i,
   input  logic [NCH*2-1:0]     div_i,
   input  logic [NCH-1:0]       cfg_wr_i,
   input  logic                 trig_i,
   input  logic [CNT_W-1:0]     count_i,
   input  logic [NCH-1:0]       flag_clr_i,
   input  logic [NCH-1:0]       cap_rd_i,
   output logic [NCH*CNT_W-1:0] cap_val_o,
   output logic [NCH-1:0]       cap_flag_o,
   output logic [NCH-1:0]       ovr_flag_o
);
   if (NCH < 4 || (NCH % 2) != 0) begin : g_bad_nch
      $error("NCH must be even and at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end
   if (FLT_W < 2 || FLT_W > 5) begin : g_bad_flt
      $error("FLT_W must be 2 to 5");
   end

   logic [NCH-1:0] raw, filt, pass;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int PAIR = ch ^ 1;

      if (ch == 0) begin : g_raw_sel
         assign raw[ch] = ch1_xor_i ? ^pin_i[2:0] : pin_i[0];
      end else begin : g_raw_pin
         assign raw[ch] = pin_i[ch];
      end

      cap_filter #(.FLT_W(FLT_W)) u_flt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw[ch]),
         .code_i (flt_cfg_i[ch*FLT_W +: FLT_W]),
         .filt_o (filt[ch])
      );

      cap_edge_sel u_sel (
         .clk      (clk),
         .rst_n    (rst_n),
         .own_i    (filt[ch]),
         .pair_i   (filt[PAIR]),
         .pol_i    (pol_i[ch]),
         .both_i   (both_i[ch]),
         .src_i    (cap_src_e'(src_sel_i[ch*2 +: 2])),
         .trig_i   (trig_i),
         .div_i    (div_i[ch*2 +: 2]),
         .cfg_wr_i (cfg_wr_i[ch]),
         .pass_o   (pass[ch])
      );

      cap_latch #(.CNT_W(CNT_W)) u_cap (
         .clk     (clk),
         .rst_n   (rst_n),
         .pass_i  (pass[ch]),
         .count_i (count_i),
         .clr_i   (flag_clr_i[ch]),
         .rd_i    (cap_rd_i[ch]),
         .val_o   (cap_val_o[ch*CNT_W +: CNT_W]),
         .flag_o  (cap_flag_o[ch]),
         .ovr_o   (ovr_flag_o[ch])
      );
   end

   AST_CH1_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (ch1_xor_i && flt_cfg_i[FLT_W-1:0] == '0)
         |=> (filt[0] == $past(^pin_i[2:0])));                    // R5
endmodule

// File: tb/sim_tmr_capture_cond.sv
`timescale 1ns/1ps
module sim_tmr_capture_cond;
   localparam int NCH = 4, CNT_W = 16, FLT_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NCH-1:0]       pin = '0, pol = '0, both = '0, cfg_wr = '0;
   logic [NCH-1:0]       fclr = '0, rd = '0;
   logic                 xsel = 1'b0, trig = 1'b0;
   logic [NCH*FLT_W-1:0] flt = '0;
   logic [NCH*2-1:0]     src = '0, dv = '0;
   logic [CNT_W-1:0]     count = '0;
   logic [NCH*CNT_W-1:0] cval;
   logic [NCH-1:0]       cflag, oflag;
   int n_chk = 0, n_fail = 0;

   // entry: {pol, both, drive_rising, expect_capture}
   localparam logic [3:0] VEC [6] = '{
      4'b0011, 4'b0000, 4'b1010, 4'b1001, 4'b0111, 4'b0101 };

   tmr_capture_cond #(.NCH(NCH), .CNT_W(CNT_W), .FLT_W(FLT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .ch1_xor_i(xsel),
      .flt_cfg_i(flt), .pol_i(pol), .both_i(both), .src_sel_i(src),
      .div_i(dv), .cfg_wr_i(cfg_wr), .trig_i(trig), .count_i(count),
      .flag_clr_i(fclr), .cap_rd_i(rd), .cap_val_o(cval),
      .cap_flag_o(cflag), .ovr_flag_o(oflag));

   always #10 clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_all();
      fclr = '1; step(1); fclr = '0;
   endtask

   task automatic pulse_trig();
      trig = 1'b1; step(1); trig = 1'b0; step(1);
   endtask

   task automatic wr_cfg(input int ch);
      cfg_wr[ch] = 1'b1; step(1); cfg_wr[ch] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 flags", {28'd0, cflag}, 32'd0);
      chk("R1 ovr", {28'd0, oflag}, 32'd0);
      chk("R1 vals", {16'd0, cval[15:0] | cval[31:16] | cval[47:32] | cval[63:48]}, 32'd0);

      // R4/R9 table walk on channel 1
      for (int i = 0; i < 6; i++) begin
         logic p, b, d, e;
         {p, b, d, e} = VEC[i];
         pol[0] = p; both[0] = b; pin[0] = ~d;
         step(3); clr_all();
         count = 16'h0100 + 16'(i);
         pin[0] = d;
         step(3);
         chk("R4 edge select", {31'd0, cflag[0]}, {31'd0, e});
         if (e) chk("R9 value", {16'd0, cval[15:0]}, {16'd0, 16'h0100 + 16'(i)});
      end
      pol = '0; both = '0;

      // R2 timing with filter bypass, channel 4
      pin[3] = 1'b0; step(3); clr_all();
      count = 16'h0222;
      pin[3] = 1'b1;
      step(1);
      chk("R2 not yet", {31'd0, cflag[3]}, 32'd0);
      step(1);
      chk("R2 capture at k+1", {31'd0, cflag[3]}, 32'd1);
      chk("R9 value ch4", {16'd0, cval[63:48]}, 32'h0222);

      // R5 parity source for channel 1
      pin = '0; step(3);
      xsel = 1'b1; step(3); clr_all();
      pin[1] = 1'b1; step(3);
      chk("R5 xor rise", {31'd0, cflag[0]}, 32'd1);
      pin[1] = 1'b0; xsel = 1'b0; step(3); clr_all();
      pin[2] = 1'b1; step(3);
      chk("R5 pin3 ignored", {31'd0, cflag[0]}, 32'd0);

      // R3 filter, channel 3: code 2 -> N=4 every clock
      flt[2*FLT_W +: FLT_W] = 4'd2;
      pin[2] = 1'b0; step(12); clr_all();
      pin[2] = 1'b1; step(3); pin[2] = 1'b0; step(8);
      chk("R3 short pulse", {31'd0, cflag[2]}, 32'd0);
      pin[2] = 1'b1; step(4); pin[2] = 1'b0; step(8);
      chk("R3 long pulse", {31'd0, cflag[2]}, 32'd1);
      // code 4 -> N=2 every second clock
      flt[2*FLT_W +: FLT_W] = 4'd4;
      step(12); clr_all();
      pin[2] = 1'b1; step(1); pin[2] = 1'b0; step(10);
      chk("R3 slow rate glitch", {31'd0, cflag[2]}, 32'd0);
      pin[2] = 1'b1; step(5); pin[2] = 1'b0; step(10);
      chk("R3 slow rate pulse", {31'd0, cflag[2]}, 32'd1);

      // R6 source select on channel 2
      src[3:2] = 2'd1;
      pin[0] = 1'b0; pin[1] = 1'b0; step(3); clr_all();
      pin[0] = 1'b1; step(3);
      chk("R6 paired source", {31'd0, cflag[1]}, 32'd1);
      src[3:2] = 2'd2; step(1); clr_all();
      pulse_trig();
      chk("R6 trigger source", {31'd0, cflag[1]}, 32'd1);
      src[3:2] = 2'd3; step(1); clr_all();
      pulse_trig(); pin[1] = 1'b1; step(3);
      chk("R6 no source", {31'd0, cflag[1]}, 32'd0);
      src[3:2] = 2'd0;

      // R7 divider on channel 4 (trigger source, every 4th)
      src[7:6] = 2'd2; dv[7:6] = 2'd2; wr_cfg(3); clr_all();
      pulse_trig(); pulse_trig(); pulse_trig();
      chk("R7 three events", {31'd0, cflag[3]}, 32'd0);
      pulse_trig();
      chk("R7 fourth event", {31'd0, cflag[3]}, 32'd1);

      // R8 configuration write clears divider (every 2nd)
      dv[7:6] = 2'd1; wr_cfg(3); clr_all();
      pulse_trig();
      wr_cfg(3);
      pulse_trig();
      chk("R8 count cleared", {31'd0, cflag[3]}, 32'd0);
      pulse_trig();
      chk("R8 second after clear", {31'd0, cflag[3]}, 32'd1);

      // R10 overcapture
      dv[7:6] = 2'd0; wr_cfg(3); clr_all();
      pulse_trig();
      chk("R10 first no ovr", {31'd0, oflag[3]}, 32'd0);
      pulse_trig();
      chk("R10 overcapture", {31'd0, oflag[3]}, 32'd1);

      // R11 clearing
      clr_all();
      chk("R11 clr flag", {31'd0, cflag[3]}, 32'd0);
      chk("R10 clr ovr", {31'd0, oflag[3]}, 32'd0);
      pulse_trig();
      rd[3] = 1'b1; step(1); rd[3] = 1'b0; step(1);
      chk("R11 read clears", {31'd0, cflag[3]}, 32'd0);
      count = 16'h0ABC;
      trig = 1'b1; fclr[3] = 1'b1; step(1); trig = 1'b0; fclr[3] = 1'b0; step(1);
      chk("R11 capture wins", {31'd0, cflag[3]}, 32'd1);
      chk("R11 new value", {16'd0, cval[63:48]}, 32'h0ABC);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule